// File: doc/BRIEF.md
# USB Event Status Register with Read-Clear

This block is the main event status word of a USB device controller, as seen by the host processor over a simple register bus. It watches a set of conditions inside the controller: the two mailbox pointer pairs, the empty signals of three receive pools, the descriptor counts of those pools against their alert thresholds, a DMA bus error and an overrun of the isochronous OUT endpoint FIFO. A condition that becomes true is latched as a sticky bit. A read of the status word returns the latched bits and clears them.

Bit 31 of the word is not latched. It is a live summary that is high while any bit of a second status register is set together with its matching enable in a second mask. A second bus address holds an interrupt enable mask. The interrupt line is high while any latched event is set and enabled in that mask. The processor reads the status word after an interrupt, and that read both reports and acknowledges every pending event.

Top module: `usb_evstat`

## Requirements
- R1: Bit 23 latches to 1 when the transmit mailbox read pointer becomes equal to its write pointer.
- R2: Bit 22 latches to 1 when the receive mailbox read pointer becomes equal to its write pointer.
- R3: Bits 21, 20 and 19 latch to 1 when the empty input of pool 2, 1 or 0 (bit index of `pool_empty`) goes high.
- R4: Bits 18, 17 and 16 latch to 1 when the remaining-descriptor count of pool 2, 1 or 0 becomes equal to that pool's threshold. Pool n uses the slice [n*CNT_W +: CNT_W] of the count and threshold buses.
- R5: Bit 10 latches on a rising DMA bus error input. Bit 9 latches on a rising isochronous FIFO overrun input.
- R6: Bit 31 reads as 1 exactly when (`stat2 & stat2_mask`) is nonzero. A read does not clear it.
- R7: Bits 30:24, 15:11 and 8:0 of the status word always read 0.
- R8: A read at address 0 (`bus_sel`=1, `bus_we`=0) loads the status word into `bus_rdata` at that clock edge, with the value from before the clear. The same edge clears every latched bit, and latched bits hold until such a read.
- R9: If a condition rises in the same cycle as a status read, its bit is 1 after that edge, and the following read returns it.
- R10: Latching happens only on the cycle a condition turns true. A condition that stays true does not set its bit again after a read. A condition already true when reset is released sets nothing until it has been false.
- R11: Address 1 holds the interrupt enable mask. A write stores only the latched-bit positions (23:16, 10, 9), and a read returns 0 elsewhere. `irq` is high while any latched bit is set together with its enable bit.
- R12: Reads at address 1 and writes do not clear latched bits.
- R13: After reset, the latched bits, the mask, `bus_rdata` and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Word address: 0 status, 1 interrupt mask |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, held between reads |
| tx_rd_ptr | input | MB_AW | Transmit mailbox read pointer |
| tx_wr_ptr | input | MB_AW | Transmit mailbox write pointer |
| rx_rd_ptr | input | MB_AW | Receive mailbox read pointer |
| rx_wr_ptr | input | MB_AW | Receive mailbox write pointer |
| pool_empty | input | 3 | Empty indication per receive pool |
| pool_left | input | 3*CNT_W | Remaining descriptor count per pool |
| pool_thresh | input | 3*CNT_W | Alert threshold per pool |
| dma_err | input | 1 | Internal bus error during DMA |
| iso_ovr | input | 1 | Isochronous OUT FIFO overrun |
| stat2 | input | 32 | Second status register contents |
| stat2_mask | input | 32 | Second interrupt mask contents |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a condition that rises in exactly the cycle the processor reads the status word. The read must return the old value, and the new event must still survive the clear. The bench reaches it by raising a pointer match on the same falling edge that issues the read strobe, so both land on one rising edge. It also holds a match across reset and across reads to show that a lasting equality does not set its bit again.

// File: rtl/usb_evstat_pkg.sv
package usb_evstat_pkg;

    localparam int STAT_W  = 32;
    localparam int NPOOL   = 3;
    localparam int NEV     = 2 + 2 * NPOOL + 2;

    localparam int BIT_SUM = 31;
    localparam int BIT_TXF = 23;
    localparam int BIT_RXF = 22;
    localparam int BIT_EMP = 19;
    localparam int BIT_ALR = 16;
    localparam int BIT_DMA = 10;
    localparam int BIT_OVR = 9;

    typedef struct packed {
        logic             tx_full;
        logic             rx_full;
        logic [NPOOL-1:0] pool_empty;
        logic [NPOOL-1:0] pool_alert;
        logic             dma_err;
        logic             iso_ovr;
    } ev_t;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } bus_op_e;

    function automatic logic [STAT_W-1:0] ev_place(input ev_t e);
        logic [STAT_W-1:0] w;
        w = '0;
        w[BIT_TXF] = e.tx_full;
        w[BIT_RXF] = e.rx_full;
        w[BIT_EMP +: NPOOL] = e.pool_empty;
        w[BIT_ALR +: NPOOL] = e.pool_alert;
        w[BIT_DMA] = e.dma_err;
        w[BIT_OVR] = e.iso_ovr;
        return w;
    endfunction

    function automatic ev_t ev_extract(input logic [STAT_W-1:0] w);
        ev_t e;
        e.tx_full    = w[BIT_TXF];
        e.rx_full    = w[BIT_RXF];
        e.pool_empty = w[BIT_EMP +: NPOOL];
        e.pool_alert = w[BIT_ALR +: NPOOL];
        e.dma_err    = w[BIT_DMA];
        e.iso_ovr    = w[BIT_OVR];
        return e;
    endfunction

    localparam logic [STAT_W-1:0] STICKY_MASK = ev_place(ev_t'({NEV{1'b1}}));

endpackage

// File: rtl/evstat_detect.sv
module evstat_detect
    import usb_evstat_pkg::*;
#(
    parameter int MB_AW = 6,
    parameter int CNT_W = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [MB_AW-1:0]       tx_rd_ptr,
    input  logic [MB_AW-1:0]       tx_wr_ptr,
    input  logic [MB_AW-1:0]       rx_rd_ptr,
    input  logic [MB_AW-1:0]       rx_wr_ptr,
    input  logic [NPOOL-1:0]       pool_empty,
    input  logic [NPOOL*CNT_W-1:0] pool_left,
    input  logic [NPOOL*CNT_W-1:0] pool_thresh,
    input  logic                   dma_err,
    input  logic                   iso_ovr,
    output ev_t                    rise
);

    ev_t lvl;
    ev_t lvl_q;
    logic [NPOOL-1:0] alert_lvl;

    generate
        for (genvar p = 0; p < NPOOL; p++) begin : g_pool
            assign alert_lvl[p] = (pool_left[p*CNT_W +: CNT_W] == pool_thresh[p*CNT_W +: CNT_W]);
        end
    endgenerate

    always_comb begin
        lvl.tx_full    = (tx_rd_ptr == tx_wr_ptr);
        lvl.rx_full    = (rx_rd_ptr == rx_wr_ptr);
        lvl.pool_empty = pool_empty;
        lvl.pool_alert = alert_lvl;
        lvl.dma_err    = dma_err;
        lvl.iso_ovr    = iso_ovr;
    end

    // History starts at all ones so that a condition present at reset
    // release must first go false before it can latch.
    always_ff @(posedge clk) begin
        if (rst) lvl_q <= ev_t'({NEV{1'b1}});
        else     lvl_q <= lvl;
    end

    assign rise = ev_t'(lvl & ~lvl_q);

endmodule

// File: rtl/evstat_sticky.sv
module evstat_sticky #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set,
    input  logic         clr,
    output logic [W-1:0] q
);

    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            always_ff @(posedge clk) begin
                if (rst)          q[i] <= 1'b0;
                else if (set[i])  q[i] <= 1'b1;
                else if (clr)     q[i] <= 1'b0;
            end
        end
    endgenerate

endmodule

// File: rtl/evstat_bus.sv
module evstat_bus
    import usb_evstat_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [STAT_W-1:0] status_word,
    input  logic [STAT_W-1:0] mask_word,
    output logic [STAT_W-1:0] bus_rdata,
    output logic              status_clr,
    output logic              mask_we
);

    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(1);

    bus_op_e op;

    always_comb begin
        if (!bus_sel)    op = OP_IDLE;
        else if (bus_we) op = OP_WRITE;
        else             op = OP_READ;
    end

    assign status_clr = (op == OP_READ)  && (bus_addr == A_STATUS);
    assign mask_we    = (op == OP_WRITE) && (bus_addr == A_MASK);

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (op == OP_READ) begin
            if (bus_addr == A_STATUS)    bus_rdata <= status_word;
            else if (bus_addr == A_MASK) bus_rdata <= mask_word;
            else                         bus_rdata <= '0;
        end
    end

endmodule

// File: rtl/usb_evstat.sv
module usb_evstat
    import usb_evstat_pkg::*;
#(
    parameter int MB_AW  = 6,
    parameter int CNT_W  = 8,
    parameter int ADDR_W = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   bus_sel,
    input  logic                   bus_we,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [31:0]            bus_wdata,
    output logic [31:0]            bus_rdata,
    input  logic [MB_AW-1:0]       tx_rd_ptr,
    input  logic [MB_AW-1:0]       tx_wr_ptr,
    input  logic [MB_AW-1:0]       rx_rd_ptr,
    input  logic [MB_AW-1:0]       rx_wr_ptr,
    input  logic [2:0]             pool_empty,
    input  logic [3*CNT_W-1:0]     pool_left,
    input  logic [3*CNT_W-1:0]     pool_thresh,
    input  logic                   dma_err,
    input  logic                   iso_ovr,
    input  logic [31:0]            stat2,
    input  logic [31:0]            stat2_mask,
    output logic                   irq
);

    ev_t              rise;
    logic [NEV-1:0]   sticky_q;
    logic [NEV-1:0]   irq_mask_q;
    logic             rd_clr;
    logic             mask_we;
    logic             summary;
    logic [STAT_W-1:0] status_word;
    logic [STAT_W-1:0] mask_word;

    evstat_detect #(.MB_AW(MB_AW), .CNT_W(CNT_W)) u_detect (
        .clk         (clk),
        .rst         (rst),
        .tx_rd_ptr   (tx_rd_ptr),
        .tx_wr_ptr   (tx_wr_ptr),
        .rx_rd_ptr   (rx_rd_ptr),
        .rx_wr_ptr   (rx_wr_ptr),
        .pool_empty  (pool_empty),
        .pool_left   (pool_left),
        .pool_thresh (pool_thresh),
        .dma_err     (dma_err),
        .iso_ovr     (iso_ovr),
        .rise        (rise)
    );

    evstat_sticky #(.W(NEV)) u_sticky (
        .clk (clk),
        .rst (rst),
        .set (rise),
        .clr (rd_clr),
        .q   (sticky_q)
    );

    always_ff @(posedge clk) begin
        if (rst)          irq_mask_q <= '0;
        else if (mask_we) irq_mask_q <= ev_extract(bus_wdata);
    end

    assign summary     = |(stat2 & stat2_mask);
    assign status_word = ev_place(ev_t'(sticky_q)) | (STAT_W'(summary) << BIT_SUM);
    assign mask_word   = ev_place(ev_t'(irq_mask_q));
    assign irq         = |(sticky_q & irq_mask_q);

    evstat_bus #(.ADDR_W(ADDR_W)) u_bus (
        .clk         (clk),
        .rst         (rst),
        .bus_sel     (bus_sel),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .status_word (status_word),
        .mask_word   (mask_word),
        .bus_rdata   (bus_rdata),
        .status_clr  (rd_clr),
        .mask_we     (mask_we)
    );

endmodule

// File: rtl/evstat_chk.sv
module evstat_chk
    import usb_evstat_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [NEV-1:0]    rise,
    input logic [NEV-1:0]    sticky,
    input logic [NEV-1:0]    mask,
    input logic              clr,
    input logic [STAT_W-1:0] rdata,
    input logic              irq
);

    localparam logic [STAT_W-1:0] LIVE = STICKY_MASK | (STAT_W'(1) << BIT_SUM);

    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rdata & ~LIVE) == '0);                                          // R7

    AST_CLR_ON_READ: assert property (@(posedge clk) disable iff (rst)
        clr |=> ((sticky & ~$past(rise)) == '0));                        // R8

    AST_RD_PRECLEAR: assert property (@(posedge clk) disable iff (rst)
        clr |=> ((rdata & STICKY_MASK) == ev_place(ev_t'($past(sticky))))); // R8

    AST_HOLD_UNTIL_READ: assert property (@(posedge clk) disable iff (rst)
        !clr |=> ((sticky & $past(sticky)) == $past(sticky)));           // R12

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (rise != '0) |=> ((sticky & $past(rise)) == $past(rise)));       // R9

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        (mask == '0) |-> !irq);                                          // R11

endmodule

bind usb_evstat evstat_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .rise   (rise),
    .sticky (sticky_q),
    .mask   (irq_mask_q),
    .clr    (rd_clr),
    .rdata  (bus_rdata),
    .irq    (irq)
);

// File: tb/usb_evstat_test.sv
`timescale 1ns/1ps
module usb_evstat_test;

    localparam int MB_AW  = 6;
    localparam int CNT_W  = 8;
    localparam int ADDR_W = 2;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                bus_sel = 1'b0;
    logic                bus_we = 1'b0;
    logic [ADDR_W-1:0]   bus_addr = '0;
    logic [31:0]         bus_wdata = '0;
    logic [31:0]         bus_rdata;
    logic [MB_AW-1:0]    tx_rd_ptr = 6'd5, tx_wr_ptr = 6'd5;
    logic [MB_AW-1:0]    rx_rd_ptr = 6'd9, rx_wr_ptr = 6'd10;
    logic [2:0]          pool_empty = '0;
    logic [3*CNT_W-1:0]  pool_left = {8'd11, 8'd11, 8'd11};
    logic [3*CNT_W-1:0]  pool_thresh = {8'd4, 8'd4, 8'd4};
    logic                dma_err = 1'b0;
    logic                iso_ovr = 1'b0;
    logic [31:0]         stat2 = '0;
    logic [31:0]         stat2_mask = '0;
    logic                irq;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    usb_evstat #(.MB_AW(MB_AW), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_rd_ptr(tx_rd_ptr), .tx_wr_ptr(tx_wr_ptr),
        .rx_rd_ptr(rx_rd_ptr), .rx_wr_ptr(rx_wr_ptr),
        .pool_empty(pool_empty), .pool_left(pool_left), .pool_thresh(pool_thresh),
        .dma_err(dma_err), .iso_ovr(iso_ovr),
        .stat2(stat2), .stat2_mask(stat2_mask), .irq(irq)
    );

    // pattern: [9] tx, [8] rx, [7:5] empty 2..0, [4:2] alert 2..0, [1] dma, [0] ovr
    localparam int NVEC = 9;
    localparam logic [41:0] VEC [NVEC] = '{
        {10'b10_000_000_00, 32'h0080_0000},   // R1
        {10'b01_000_000_00, 32'h0040_0000},   // R2
        {10'b00_100_000_00, 32'h0020_0000},   // R3
        {10'b00_011_000_00, 32'h0018_0000},   // R3
        {10'b00_000_101_00, 32'h0005_0000},   // R4
        {10'b00_000_010_00, 32'h0002_0000},   // R4
        {10'b00_000_000_10, 32'h0000_0400},   // R5
        {10'b00_000_000_01, 32'h0000_0200},   // R5
        {10'b11_111_111_11, 32'h00FF_0600}    // R7
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic drive_cond(input logic [9:0] p);
        tx_wr_ptr = p[9] ? tx_rd_ptr : tx_rd_ptr + 6'd1;
        rx_wr_ptr = p[8] ? rx_rd_ptr : rx_rd_ptr + 6'd1;
        pool_empty = p[7:5];
        for (int k = 0; k < 3; k++)
            pool_left[k*CNT_W +: CNT_W] = p[2+k] ? pool_thresh[k*CNT_W +: CNT_W]
                                                 : pool_thresh[k*CNT_W +: CNT_W] + 8'd7;
        dma_err = p[1];
        iso_ovr = p[0];
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got %0d cycles expected below 20000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        // tx pointers equal through reset
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R13 rdata after reset", bus_rdata, 32'h0);
        check("R13 irq after reset", {31'h0, irq}, 32'h0);
        repeat (2) @(negedge clk);
        bus_read(2'd0, d);
        check("R10 match held over reset", d, 32'h0);
        bus_read(2'd1, d);
        check("R13 mask after reset", d, 32'h0);

        for (int v = 0; v < NVEC; v++) begin
            @(negedge clk); drive_cond(10'h0);
            @(negedge clk); drive_cond(VEC[v][41:32]);
            @(negedge clk); drive_cond(10'h0);
            bus_read(2'd0, d);
            check($sformatf("R1-5 vector %0d status (see table tag)", v), d, VEC[v][31:0]);
            bus_read(2'd0, d);
            check("R8 cleared by previous read", d, 32'h0);
        end

        // R10: persisting match
        @(negedge clk); drive_cond(10'b10_000_000_00);
        repeat (3) @(negedge clk);
        bus_read(2'd0, d);
        check("R10 first read of held match", d, 32'h0080_0000);
        repeat (2) @(negedge clk);
        bus_read(2'd0, d);
        check("R10 held match does not re-latch", d, 32'h0);
        @(negedge clk); drive_cond(10'h0);

        // R9: rise on the read edge
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 2'd0;
        drive_cond(10'b01_000_000_00);
        @(negedge clk);
        bus_sel = 1'b0;
        check("R9 read returns pre-set value", bus_rdata, 32'h0);
        @(negedge clk); drive_cond(10'h0);
        bus_read(2'd0, d);
        check("R9 event survives clear", d, 32'h0040_0000);

        // R6: live summary
        @(negedge clk); stat2 = 32'h0000_0104; stat2_mask = 32'h0000_0004;
        bus_read(2'd0, d);
        check("R6 summary set", d, 32'h8000_0000);
        bus_read(2'd0, d);
        check("R6 summary not cleared by read", d, 32'h8000_0000);
        @(negedge clk); stat2_mask = 32'h0000_0002;
        bus_read(2'd0, d);
        check("R6 summary follows mask", d, 32'h0);

        // R11: mask register
        bus_write(2'd1, 32'hFFFF_FFFF);
        bus_read(2'd1, d);
        check("R11 mask readback positions", d, 32'h00FF_0600);
        bus_write(2'd1, 32'h0000_0400);
        @(negedge clk); iso_ovr = 1'b1;
        @(negedge clk); iso_ovr = 1'b0;
        check("R11 disabled event no irq", {31'h0, irq}, 32'h0);
        bus_read(2'd0, d);
        @(negedge clk); dma_err = 1'b1;
        @(negedge clk); dma_err = 1'b0;
        check("R11 enabled event raises irq", {31'h0, irq}, 32'h1);
        bus_read(2'd1, d);
        check("R12 mask read keeps irq", {31'h0, irq}, 32'h1);
        bus_write(2'd0, 32'h0);
        bus_read(2'd0, d);
        check("R12 write does not clear", d, 32'h0000_0400);
        check("R11 irq drops after clear", {31'h0, irq}, 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule